// File: doc/BRIEF.md
# Radix-4 Butterfly with Block-Floating-Point Scaling

This block is a pipelined radix-4 decimation-in-frequency butterfly. It takes four complex fixed-point samples and three complex twiddle factors. It first forms the two levels of add and subtract that a frequency-split butterfly needs. It then scales the wide sums down by two bits so each value fits a 16x16 signed multiplier. Three of the four outputs are rotated by their twiddles. Each rotated value goes through a 32-bit product sum, a 15-bit arithmetic right shift and saturation. The output at index zero has a unit twiddle and skips the multiplier.

The block is meant to run inside a block-floating-point FFT stage. The engine in front of it has already aligned its data, so at least one sample in the block has a single sign bit. A separate normaliser keeps the block exponent. The final shift is 15 bits and not 16. This gains one bit of dynamic range, at the cost of overflow for a few extreme inputs. When that overflow happens the result is clipped and a sticky flag records it.

Both data interfaces are valid/ready. One enable drives all four pipeline registers. It is high when the output register is empty or the output is being taken. A stalled output therefore freezes the whole pipeline, and `in_ready` drops in the same cycle. `in_ready` is a combinational function of `out_ready` and `out_valid`. The input side may hold or change its data freely while `in_valid` is low.

Top module: `bfp4_butterfly`

## Requirements
- R1: Output lane 0 equals (x0+x1+x2+x3) >>> 2, separately for the real and the imaginary parts. The sums are exact and the shift is arithmetic (floor). Lane 0 uses no twiddle and never saturates. Lane k occupies bits [16k+15:16k] of `out_re`/`out_im`, and input sample k occupies the same bits of `in_re`/`in_im`.
- R2: Let B = x0-x2, D = x1-x3 and A = x0+x2, C = x1+x3. The multiplier operands are formed as follows, each part then shifted right arithmetically by 2 bits:
  - lane 1: (Br+Di, Bi-Dr)
  - lane 2: (Ar-Cr, Ai-Ci)
  - lane 3: (Br-Di, Bi+Dr)
- R3: Lane k (k = 1..3) with operand (sr, si) uses twiddle lane k-1 of `tw_re`/`tw_im`, that is bits [16(k-1)+15:16(k-1)]. Its outputs are:
  - real part: (sr*wr - si*wi) >>> 15
  - imaginary part: (sr*wi + si*wr) >>> 15
  A twiddle of 0x7FFF stands for +1.
- R4: A shifted result above 32767 is output as 32767 (0x7FFF). A result below -32768 is output as -32768 (0x8000).
- R5: `ovf_flag` rises in the same cycle as the output that carries a saturated value. It then stays high until `ovf_clr` is sampled high. If a saturation and a clear arrive in the same cycle, the flag is set.
- R6: With `out_ready` held high, a sample accepted in cycle n appears with `out_valid` high in cycle n+4, and not earlier.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re` and `out_im` hold their values and `in_ready` is low.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. Every accepted sample is delivered exactly once, in order of acceptance.
- R9: After reset, `out_valid` and `ovf_flag` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample set valid |
| in_ready | output | 1 | Block accepts an input this cycle |
| in_re | input | 64 | Real parts of samples x0..x3, lane k at bits 16k+15:16k |
| in_im | input | 64 | Imaginary parts of samples x0..x3 |
| tw_re | input | 48 | Real parts of twiddles for output lanes 1..3 |
| tw_im | input | 48 | Imaginary parts of twiddles for output lanes 1..3 |
| out_valid | output | 1 | Output set valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_re | output | 64 | Real parts of outputs y0..y3 |
| out_im | output | 64 | Imaginary parts of outputs y0..y3 |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf_flag | output | 1 | Sticky saturation indicator |

## Verification
On every cycle the assertions check the following:
- A stalled output holds its value.
- Valid data in the third stage reaches the output register whenever the pipeline advances.
- The overflow flag stays set until it is cleared, and a clear with no new saturation drops it.

The arithmetic can only be shown by the bench scenarios. The bench sweeps corner values and random values through the butterfly equations, the floor shifts and saturation, and compares against its own model. The scenarios also show the four-cycle latency, delivery in order under random gaps and back-pressure, and the priority of set over clear on the flag.

// File: rtl/bfp4_pkg.sv
`timescale 1ns/1ps
package bfp4_pkg;
  localparam int NUM_IN = 4;
  localparam int NUM_TW = NUM_IN - 1;
  localparam int NUM_STAGES = 4;
  typedef logic [NUM_STAGES-1:0] stage_vld_t;
endpackage

// File: rtl/bfp4_addsub.sv
`timescale 1ns/1ps
module bfp4_addsub #(
  parameter int DW        = 16,
  parameter int PRE_SHIFT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [bfp4_pkg::NUM_IN*DW-1:0] x_re,
  input  logic [bfp4_pkg::NUM_IN*DW-1:0] x_im,
  output logic [bfp4_pkg::NUM_IN*DW-1:0] op_re,
  output logic [bfp4_pkg::NUM_IN*DW-1:0] op_im
);
  localparam int W1 = DW + 1;

  typedef logic signed [DW-1:0] samp_t;
  typedef logic signed [W1-1:0] lvl1_t;

  samp_t xr [bfp4_pkg::NUM_IN];
  samp_t xi [bfp4_pkg::NUM_IN];

  for (genvar k = 0; k < bfp4_pkg::NUM_IN; k++) begin : g_unpack
    assign xr[k] = x_re[k*DW +: DW];
    assign xi[k] = x_im[k*DW +: DW];
  end

  function automatic lvl1_t wadd(input samp_t p, input samp_t q);
    return $signed({p[DW-1], p}) + $signed({q[DW-1], q});
  endfunction

  function automatic lvl1_t wsub(input samp_t p, input samp_t q);
    return $signed({p[DW-1], p}) - $signed({q[DW-1], q});
  endfunction

  function automatic samp_t sadd(input lvl1_t p, input lvl1_t q);
    return DW'(($signed({p[W1-1], p}) + $signed({q[W1-1], q})) >>> PRE_SHIFT);
  endfunction

  function automatic samp_t ssub(input lvl1_t p, input lvl1_t q);
    return DW'(($signed({p[W1-1], p}) - $signed({q[W1-1], q})) >>> PRE_SHIFT);
  endfunction

  // stage 1: first level of the frequency split
  lvl1_t sum02_r, sum02_i, dif02_r, dif02_i;
  lvl1_t sum13_r, sum13_i, dif13_r, dif13_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum02_r <= '0; sum02_i <= '0; dif02_r <= '0; dif02_i <= '0;
      sum13_r <= '0; sum13_i <= '0; dif13_r <= '0; dif13_i <= '0;
    end else if (en) begin
      sum02_r <= wadd(xr[0], xr[2]);
      sum02_i <= wadd(xi[0], xi[2]);
      dif02_r <= wsub(xr[0], xr[2]);
      dif02_i <= wsub(xi[0], xi[2]);
      sum13_r <= wadd(xr[1], xr[3]);
      sum13_i <= wadd(xi[1], xi[3]);
      dif13_r <= wsub(xr[1], xr[3]);
      dif13_i <= wsub(xi[1], xi[3]);
    end
  end

  // stage 2: second level, rotation by -j / +j folded in, then 2-bit down-scale
  samp_t o_r [bfp4_pkg::NUM_IN];
  samp_t o_i [bfp4_pkg::NUM_IN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < bfp4_pkg::NUM_IN; k++) begin
        o_r[k] <= '0;
        o_i[k] <= '0;
      end
    end else if (en) begin
      o_r[0] <= sadd(sum02_r, sum13_r);
      o_i[0] <= sadd(sum02_i, sum13_i);
      o_r[1] <= sadd(dif02_r, dif13_i);
      o_i[1] <= ssub(dif02_i, dif13_r);
      o_r[2] <= ssub(sum02_r, sum13_r);
      o_i[2] <= ssub(sum02_i, sum13_i);
      o_r[3] <= ssub(dif02_r, dif13_i);
      o_i[3] <= sadd(dif02_i, dif13_r);
    end
  end

  for (genvar k = 0; k < bfp4_pkg::NUM_IN; k++) begin : g_pack
    assign op_re[k*DW +: DW] = o_r[k];
    assign op_im[k*DW +: DW] = o_i[k];
  end
endmodule

// File: rtl/bfp4_cmul.sv
`timescale 1ns/1ps
module bfp4_cmul #(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic signed [DW-1:0]   sr,
  input  logic signed [DW-1:0]   si,
  input  logic signed [DW-1:0]   wr,
  input  logic signed [DW-1:0]   wi,
  output logic signed [2*DW-1:0] p_rr,
  output logic signed [2*DW-1:0] p_ii,
  output logic signed [2*DW-1:0] p_ri,
  output logic signed [2*DW-1:0] p_ir
);
  // stage 3: four real partial products of the complex rotation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rr <= '0;
      p_ii <= '0;
      p_ri <= '0;
      p_ir <= '0;
    end else if (en) begin
      p_rr <= sr * wr;
      p_ii <= si * wi;
      p_ri <= sr * wi;
      p_ir <= si * wr;
    end
  end
endmodule

// File: rtl/bfp4_scale_sat.sv
`timescale 1ns/1ps
module bfp4_scale_sat #(
  parameter int DW         = 16,
  parameter int POST_SHIFT = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic signed [2*DW-1:0] p_rr,
  input  logic signed [2*DW-1:0] p_ii,
  input  logic signed [2*DW-1:0] p_ri,
  input  logic signed [2*DW-1:0] p_ir,
  output logic                   sat_next,
  output logic signed [DW-1:0]   y_re,
  output logic signed [DW-1:0]   y_im
);
  localparam int PW = 2 * DW;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] HI = SW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);
  localparam logic signed [DW-1:0] HI_OUT = DW'(HI);
  localparam logic signed [DW-1:0] LO_OUT = DW'(LO);

  logic signed [SW-1:0] sum_re, sum_im, sh_re, sh_im;
  logic                 hi_re, lo_re, hi_im, lo_im;
  logic signed [DW-1:0] cl_re, cl_im;

  always_comb begin
    sum_re = $signed({p_rr[PW-1], p_rr}) - $signed({p_ii[PW-1], p_ii});
    sum_im = $signed({p_ri[PW-1], p_ri}) + $signed({p_ir[PW-1], p_ir});
    sh_re  = sum_re >>> POST_SHIFT;
    sh_im  = sum_im >>> POST_SHIFT;
    hi_re  = sh_re > HI;
    lo_re  = sh_re < LO;
    hi_im  = sh_im > HI;
    lo_im  = sh_im < LO;
    cl_re  = hi_re ? HI_OUT : (lo_re ? LO_OUT : sh_re[DW-1:0]);
    cl_im  = hi_im ? HI_OUT : (lo_im ? LO_OUT : sh_im[DW-1:0]);
    sat_next = hi_re | lo_re | hi_im | lo_im;
  end

  // stage 4: clipped result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_re <= '0;
      y_im <= '0;
    end else if (en) begin
      y_re <= cl_re;
      y_im <= cl_im;
    end
  end
endmodule

// File: rtl/bfp4_butterfly.sv
`timescale 1ns/1ps
module bfp4_butterfly #(
  parameter int DW         = 16,
  parameter int PRE_SHIFT  = 2,
  parameter int POST_SHIFT = 15
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [bfp4_pkg::NUM_IN*DW-1:0] in_re,
  input  logic [bfp4_pkg::NUM_IN*DW-1:0] in_im,
  input  logic [bfp4_pkg::NUM_TW*DW-1:0] tw_re,
  input  logic [bfp4_pkg::NUM_TW*DW-1:0] tw_im,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [bfp4_pkg::NUM_IN*DW-1:0] out_re,
  output logic [bfp4_pkg::NUM_IN*DW-1:0] out_im,
  input  logic                           ovf_clr,
  output logic                           ovf_flag
);
  import bfp4_pkg::*;

  localparam int TWB = NUM_TW * DW;

  logic       en;
  stage_vld_t vld;

  assign en        = !vld[NUM_STAGES-1] || out_ready;
  assign in_ready  = en;
  assign out_valid = vld[NUM_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (en) vld <= {vld[NUM_STAGES-2:0], in_valid};
  end

  // twiddles travel alongside the add/sub stages
  logic [TWB-1:0] tw1_re, tw1_im, tw2_re, tw2_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw1_re <= '0; tw1_im <= '0; tw2_re <= '0; tw2_im <= '0;
    end else if (en) begin
      tw1_re <= tw_re; tw1_im <= tw_im;
      tw2_re <= tw1_re; tw2_im <= tw1_im;
    end
  end

  logic [NUM_IN*DW-1:0] op_re, op_im;

  bfp4_addsub #(.DW(DW), .PRE_SHIFT(PRE_SHIFT)) i_addsub (
    .clk(clk), .rst_n(rst_n), .en(en),
    .x_re(in_re), .x_im(in_im),
    .op_re(op_re), .op_im(op_im)
  );

  // lane 0: unit twiddle, operand delayed through stages 3 and 4
  logic signed [DW-1:0] l0_re3, l0_im3, l0_re4, l0_im4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l0_re3 <= '0; l0_im3 <= '0; l0_re4 <= '0; l0_im4 <= '0;
    end else if (en) begin
      l0_re3 <= op_re[DW-1:0];
      l0_im3 <= op_im[DW-1:0];
      l0_re4 <= l0_re3;
      l0_im4 <= l0_im3;
    end
  end

  assign out_re[DW-1:0] = l0_re4;
  assign out_im[DW-1:0] = l0_im4;

  logic [NUM_TW-1:0] lane_sat;

  for (genvar k = 1; k < NUM_IN; k++) begin : g_rot
    logic signed [2*DW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [DW-1:0]   y_re, y_im;

    bfp4_cmul #(.DW(DW)) i_cmul (
      .clk(clk), .rst_n(rst_n), .en(en),
      .sr(op_re[k*DW +: DW]), .si(op_im[k*DW +: DW]),
      .wr(tw2_re[(k-1)*DW +: DW]), .wi(tw2_im[(k-1)*DW +: DW]),
      .p_rr(p_rr), .p_ii(p_ii), .p_ri(p_ri), .p_ir(p_ir)
    );

    bfp4_scale_sat #(.DW(DW), .POST_SHIFT(POST_SHIFT)) i_sat (
      .clk(clk), .rst_n(rst_n), .en(en),
      .p_rr(p_rr), .p_ii(p_ii), .p_ri(p_ri), .p_ir(p_ir),
      .sat_next(lane_sat[k-1]),
      .y_re(y_re), .y_im(y_im)
    );

    assign out_re[k*DW +: DW] = y_re;
    assign out_im[k*DW +: DW] = y_im;
  end

  // sticky overflow: a new saturation wins over a clear
  logic sat_load;
  assign sat_load = en && vld[NUM_STAGES-2] && (|lane_sat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (sat_load) ovf_flag <= 1'b1;
    else if (ovf_clr)  ovf_flag <= 1'b0;
  end

  // R7: a stalled output keeps its value
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im));

  // R6: valid data in stage 3 reaches the output when the pipe advances
  a_r6_flow: assert property (@(posedge clk) disable iff (!rst_n)
    en && vld[NUM_STAGES-2] |=> out_valid);

  // R5: flag stays up until cleared
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);

  // R5: clear with no new saturation drops the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !sat_load |=> !ovf_flag);
endmodule

// File: tb/test_bfp4_butterfly.sv
`timescale 1ns/1ps
module test_bfp4_butterfly;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, ovf_clr = 1'b0;
  logic in_ready, out_valid, ovf_flag;
  logic [63:0] in_re = '0, in_im = '0, out_re, out_im;
  logic [47:0] tw_re = '0, tw_im = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bfp4_butterfly i_bfp4_butterfly (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .tw_re(tw_re), .tw_im(tw_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clip(input longint v, output bit s);
    s = 0;
    if (v > 32767) begin s = 1; return 32767; end
    if (v < -32768) begin s = 1; return -32768; end
    return int'(v);
  endfunction

  // independent butterfly model
  function automatic void model(input logic [63:0] xr, xi, input logic [47:0] wr, wi,
                                output logic [63:0] yr, yi, output bit sat);
    int r[4], m[4], s_r[4], s_i[4];
    bit s;
    for (int k = 0; k < 4; k++) begin
      r[k] = int'($signed(xr[k*16 +: 16]));
      m[k] = int'($signed(xi[k*16 +: 16]));
    end
    s_r[0] = (r[0] + r[1] + r[2] + r[3]) >>> 2;
    s_i[0] = (m[0] + m[1] + m[2] + m[3]) >>> 2;
    s_r[2] = ((r[0] + r[2]) - (r[1] + r[3])) >>> 2;
    s_i[2] = ((m[0] + m[2]) - (m[1] + m[3])) >>> 2;
    s_r[1] = ((r[0] - r[2]) + (m[1] - m[3])) >>> 2;
    s_i[1] = ((m[0] - m[2]) - (r[1] - r[3])) >>> 2;
    s_r[3] = ((r[0] - r[2]) - (m[1] - m[3])) >>> 2;
    s_i[3] = ((m[0] - m[2]) + (r[1] - r[3])) >>> 2;
    sat = 0;
    yr[15:0] = 16'(s_r[0]);
    yi[15:0] = 16'(s_i[0]);
    for (int k = 1; k < 4; k++) begin
      longint a, b, c, d;
      a = longint'($signed(wr[(k-1)*16 +: 16]));
      b = longint'($signed(wi[(k-1)*16 +: 16]));
      c = longint'(s_r[k]);
      d = longint'(s_i[k]);
      yr[k*16 +: 16] = 16'(clip((c * a - d * b) >>> 15, s)); sat |= s;
      yi[k*16 +: 16] = 16'(clip((c * b + d * a) >>> 15, s)); sat |= s;
    end
  endfunction

  function automatic logic [15:0] corner(input int i);
    case (i % 5)
      0: return 16'h8000;
      1: return 16'hFFFF;
      2: return 16'h0000;
      3: return 16'h0001;
      default: return 16'h7FFF;
    endcase
  endfunction

  task automatic gen(input int idx, output logic [63:0] xr, xi, output logic [47:0] wr, wi);
    if (idx < 625) begin
      int q = idx;
      for (int k = 0; k < 4; k++) begin
        xr[k*16 +: 16] = corner(q);
        xi[k*16 +: 16] = corner(q + 2 * k + 1);
        q = q / 5;
      end
      for (int k = 0; k < 3; k++) begin
        wr[k*16 +: 16] = corner(idx + k);
        wi[k*16 +: 16] = corner(idx / 3 + 2 * k);
      end
    end else begin
      xr = {$urandom, $urandom};
      xi = {$urandom, $urandom};
      wr = {$urandom, $urandom};
      wi = {$urandom, $urandom};
    end
  endtask

  task automatic compare(input logic [63:0] er, ei, input string tag0, input string tagk);
    check(out_re[15:0] == er[15:0] && out_im[15:0] == ei[15:0], tag0,
          {out_re[15:0], out_im[15:0]}, {er[15:0], ei[15:0]});
    check(out_re[63:16] == er[63:16] && out_im[63:16] == ei[63:16], tagk,
          out_re[63:16], er[63:16]);
  endtask

  // one item through an idle pipe with out_ready high; returns negedges to output
  task automatic send_one(input logic [63:0] xr, xi, input logic [47:0] wr, wi, output int lat);
    @(negedge clk);
    in_re = xr; in_im = xi; tw_re = wr; tw_im = wi;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] xr, xi, er, ei;
    logic [47:0] wr, wi;
    bit s;
    int lat;
    int sent, nvec;
    bit have, stalled, sweep_sat, ready_ok;
    logic [63:0] hold_re, hold_im;
    logic [63:0] q_re[$], q_im[$];

    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(ovf_flag == 1'b0, "R9 ovf_flag", ovf_flag, 0);
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 latency, R1/R3 with unit twiddles 0x7FFF
    xr = {16'd400, -16'sd1200, 16'd3000, 16'd100};
    xi = {-16'sd50, 16'd700, 16'd20, -16'sd900};
    wr = {3{16'h7FFF}}; wi = '0;
    model(xr, xi, wr, wi, er, ei, s);
    send_one(xr, xi, wr, wi, lat);
    check(lat == 4, "R6 latency", lat, 4);
    compare(er, ei, "R1 unit lane0", "R3 unit twiddle");
    @(negedge clk);
    check(out_valid == 1'b0, "R8 single delivery", out_valid, 0);

    // R4/R5 forced saturation in lane 1
    xr = {16'h8000, 16'h0000, 16'h0000, 16'h7FFF};
    xi = {16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000};
    wr = {3{16'h7FFF}}; wi = {3{16'h7FFF}};
    model(xr, xi, wr, wi, er, ei, s);
    check(s == 1'b1, "R4 vector saturates", s, 1);
    send_one(xr, xi, wr, wi, lat);
    check(out_re[31:16] == 16'h7FFF, "R4 clip high", out_re[31:16], 16'h7FFF);
    compare(er, ei, "R1 sat vector lane0", "R4 sat vector");
    check(ovf_flag == 1'b1, "R5 flag with output", ovf_flag, 1);
    xr = 64'h0001_0002_0003_0004; xi = '0; wr = {3{16'h4000}}; wi = '0;
    send_one(xr, xi, wr, wi, lat);
    check(ovf_flag == 1'b1, "R5 sticky", ovf_flag, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    check(ovf_flag == 1'b0, "R5 cleared", ovf_flag, 0);

    // R5 set beats clear: clear while the saturating sample enters the output stage
    xr = {16'h8000, 16'h0000, 16'h0000, 16'h7FFF};
    xi = {16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000};
    wr = {3{16'h7FFF}}; wi = {3{16'h7FFF}};
    @(negedge clk);
    in_re = xr; in_im = xi; tw_re = wr; tw_im = wi; in_valid = 1'b1;
    @(negedge clk) in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    check(out_valid == 1'b1 && ovf_flag == 1'b1, "R5 set over clear", ovf_flag, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;

    // sweep: corner grid plus random, random gaps and back-pressure
    nvec = 2200; sent = 0; have = 0; stalled = 0; sweep_sat = 0; ready_ok = 1;
    while (sent < nvec || q_re.size() != 0 || have) begin
      @(negedge clk);
      if (stalled) begin
        check(out_valid && out_re == hold_re && out_im == hold_im, "R7 hold",
              out_re, hold_re);
      end
      if (!have && sent < nvec && ($urandom % 4 != 0)) begin
        gen(sent, xr, xi, wr, wi);
        in_re = xr; in_im = xi; tw_re = wr; tw_im = wi;
        have = 1;
      end
      in_valid = have;
      out_ready = ($urandom % 10) < 7;
      #1;
      if (in_ready != (!out_valid || out_ready)) ready_ok = 0;
      stalled = out_valid && !out_ready;
      if (stalled) begin
        hold_re = out_re; hold_im = out_im;
        check(!in_ready, "R7 in_ready low", in_ready, 0);
      end
      if (out_valid && out_ready) begin
        if (q_re.size() == 0) check(0, "R8 extra output", 1, 0);
        else begin
          er = q_re.pop_front(); ei = q_im.pop_front();
          compare(er, ei, "R1 sweep lane0", "R3 sweep lanes R2");
        end
      end
      if (in_valid && in_ready) begin
        model(in_re, in_im, tw_re, tw_im, er, ei, s);
        sweep_sat |= s;
        q_re.push_back(er); q_im.push_back(ei);
        have = 0; sent++;
      end
    end
    check(ready_ok, "R8 ready rule", ready_ok, 1);
    @(negedge clk);
    in_valid = 1'b0;
    if (sweep_sat) check(ovf_flag, "R5 sweep flag", ovf_flag, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule